// File: doc/BRIEF.md
# Debug Access Domain Gate

This block decides, at every cycle, which debug access paths of a chip are open. It serves seven debug domains and three debug command permissions, ten entries in all. Each entry has a two-bit policy code fixed at manufacture. The code closes the entry for good, opens it for good, or opens it only after a debug-credential check has succeeded.

The credential check itself runs outside the block: the signature validation and the challenge exchange, which uses a 16-byte random challenge per attempt. The block receives the outcome of that check as a one-cycle strobe. With the strobe come the entries the credential grants, the unique ID the credential is bound to, and the index of the key that signed it. The block then applies two last filters. When ID enforcement is on, the credential's bound ID must equal the device ID. The signing key must not be marked revoked.

An accepted grant opens the after-authentication entries it names. They stay open until the next reset. Permanently enabled entries are open straight out of reset.

Top module: `dbg_domain_policy`

## Requirements
- R1: Entry i takes its policy code from `pol_cfg[2i+1:2i]`. Code 2'b00 and code 2'b10 both keep the entry closed at all times, whatever has been granted.
- R2: Code 2'b11 keeps the entry open at all times, including during reset and with no authentication.
- R3: Code 2'b01 opens the entry only after an accepted authentication whose `grant_mask` has bit i set. The enable rises in the cycle after the clock edge that samples `auth_ok`.
- R4: When `enforce_uid` is 1, a strobe whose `cred_uid` differs from `dev_uid` is rejected and changes nothing. When `enforce_uid` is 0, the IDs are not compared.
- R5: A strobe whose `cred_key_idx` selects a set bit of `key_revoked` is rejected and changes nothing.
- R6: Accepted grants accumulate (OR) and persist until reset. Changes to `grant_mask` while `auth_ok` is low have no effect.
- R7: Asserting `rst_n` low clears all granted access at once. Only code 2'b11 entries stay open.
- R8: Entry order. Entries 0 to 6 are the domains, driving `dom_en[0..6]`:
  - non-secure non-invasive
  - non-secure invasive
  - secure non-invasive
  - secure invasive
  - test access port
  - secondary-core invasive
  - secondary-core non-invasive

  Entries 7 to 9 drive `cmd_en[0..2]`: ISP boot, field-return analysis, flash mass erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pol_cfg | input | 20 | Two-bit policy code per entry |
| grant_mask | input | 10 | Entries granted by the presented credential |
| auth_ok | input | 1 | One-cycle strobe: credential signature validated |
| enforce_uid | input | 1 | Require credential ID to match device ID |
| dev_uid | input | 128 | Device unique ID |
| cred_uid | input | 128 | ID the credential is bound to |
| key_revoked | input | 4 | Revocation flag per debug key |
| cred_key_idx | input | 2 | Index of the key that signed the credential |
| dom_en | output | 7 | Enable per debug domain |
| cmd_en | output | 3 | Enable per debug command |

## Verification
The bench aims at each way a flawed gate could leak or lose access. A design that decodes the reserved code 2'b10 as open would expose a domain meant to stay shut. A design that checks the ID even with enforcement off, or skips the check with enforcement on, would either refuse valid field credentials or accept credentials bound to another device. The bench also presents a revoked key index and toggles `grant_mask` while the strobe is low. It resets after grants to confirm that only permanent entries survive, and stacks partial grants to confirm that earlier access is kept. A long run with random stimulus and random resets then compares every output with an independent model on each clock.

// File: rtl/dbg_pol_pkg.sv
package dbg_pol_pkg;

  typedef enum logic [1:0] {
    POL_OFF  = 2'b00,
    POL_AUTH = 2'b01,
    POL_RSVD = 2'b10,
    POL_ON   = 2'b11
  } pol_e;

  // entry is open regardless of authentication
  function automatic logic pol_always(input logic [1:0] code);
    return code == POL_ON;
  endfunction

  // entry may be opened by an accepted credential
  function automatic logic pol_gated(input logic [1:0] code);
    return code == POL_AUTH;
  endfunction

endpackage

// File: rtl/dbg_cred_filter.sv
module dbg_cred_filter #(
  parameter int UID_W = 128,
  parameter int KEYS  = 4,
  localparam int KIW  = (KEYS > 1) ? $clog2(KEYS) : 1
) (
  input  logic             auth_ok,
  input  logic             enforce_uid,
  input  logic [UID_W-1:0] dev_uid,
  input  logic [UID_W-1:0] cred_uid,
  input  logic [KEYS-1:0]  key_revoked,
  input  logic [KIW-1:0]   cred_key_idx,
  output logic             uid_bad,
  output logic             key_bad,
  output logic             accept
);
  localparam int KPAD = 1 << KIW;

  logic [KPAD-1:0] rev_ext;

  // indices past the key table count as revoked
  generate
    if (KPAD > KEYS) begin : g_pad
      assign rev_ext = {{(KPAD-KEYS){1'b1}}, key_revoked};
    end else begin : g_nopad
      assign rev_ext = key_revoked;
    end
  endgenerate

  assign uid_bad = enforce_uid && (dev_uid != cred_uid);
  assign key_bad = rev_ext[cred_key_idx];
  assign accept  = auth_ok && !uid_bad && !key_bad;

endmodule

// File: rtl/dbg_grant_latch.sv
module dbg_grant_latch #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic [N-1:0] grant_mask,
  output logic [N-1:0] grant_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      grant_q <= '0;
    else if (accept) grant_q <= grant_q | grant_mask;
  end

  // R6: granted bits never drop while out of reset
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_q) |=> ((grant_q & $past(grant_q)) == $past(grant_q)));

  // R3: a new grant bit needs an accepted strobe naming it
  a_r3_only_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (|(grant_q & ~$past(grant_q))) |->
      ($past(accept) && ((grant_q & ~$past(grant_q) & ~$past(grant_mask)) == '0)));

endmodule

// File: rtl/dbg_entry_gate.sv
module dbg_entry_gate
  import dbg_pol_pkg::*;
#(
  parameter int N = 10
) (
  input  logic [2*N-1:0] pol_cfg,
  input  logic [N-1:0]   grant_q,
  output logic [N-1:0]   en
);

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [1:0] code;
    assign code  = pol_cfg[2*i +: 2];
    assign en[i] = pol_always(code) | (pol_gated(code) & grant_q[i]);
  end

endmodule

// File: rtl/dbg_domain_policy.sv
module dbg_domain_policy
  import dbg_pol_pkg::*;
#(
  parameter int NDOM  = 7,
  parameter int NCMD  = 3,
  parameter int UID_W = 128,
  parameter int KEYS  = 4,
  localparam int N    = NDOM + NCMD,
  localparam int KIW  = (KEYS > 1) ? $clog2(KEYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2*N-1:0]   pol_cfg,
  input  logic [N-1:0]     grant_mask,
  input  logic             auth_ok,
  input  logic             enforce_uid,
  input  logic [UID_W-1:0] dev_uid,
  input  logic [UID_W-1:0] cred_uid,
  input  logic [KEYS-1:0]  key_revoked,
  input  logic [KIW-1:0]   cred_key_idx,
  output logic [NDOM-1:0]  dom_en,
  output logic [NCMD-1:0]  cmd_en
);

  logic         uid_bad, key_bad, accept;
  logic [N-1:0] grant_q, en_all;

  dbg_cred_filter #(.UID_W(UID_W), .KEYS(KEYS)) u_filter (
    .auth_ok     (auth_ok),
    .enforce_uid (enforce_uid),
    .dev_uid     (dev_uid),
    .cred_uid    (cred_uid),
    .key_revoked (key_revoked),
    .cred_key_idx(cred_key_idx),
    .uid_bad     (uid_bad),
    .key_bad     (key_bad),
    .accept      (accept)
  );

  dbg_grant_latch #(.N(N)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .grant_mask(grant_mask),
    .grant_q   (grant_q)
  );

  dbg_entry_gate #(.N(N)) u_gate (
    .pol_cfg(pol_cfg),
    .grant_q(grant_q),
    .en     (en_all)
  );

  // R8: domains occupy the low entries, commands follow
  assign dom_en = en_all[NDOM-1:0];
  assign cmd_en = en_all[N-1:NDOM];

  // R4: an ID mismatch under enforcement leaves grants untouched
  a_r4_uid_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (auth_ok && enforce_uid && (dev_uid != cred_uid)) |=> $stable(grant_q));

  // R5: a revoked signing key leaves grants untouched
  a_r5_revoked: assert property (@(posedge clk) disable iff (!rst_n)
    (auth_ok && key_bad) |=> $stable(grant_q));

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R1: closed codes never open
    a_r1_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (pol_cfg[2*i] == 1'b0) |-> !en_all[i]);
    // R2: permanent code is open with no grant
    a_r2_perm: assert property (@(posedge clk) disable iff (!rst_n)
      (pol_cfg[2*i +: 2] == 2'b11) |-> en_all[i]);
  end

endmodule

// File: tb/dbg_domain_policy_tb.sv
`timescale 1ns/1ps
module dbg_domain_policy_tb;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [19:0]   pol_cfg = '0;
  logic [9:0]    grant_mask = '0;
  logic          auth_ok = 1'b0;
  logic          enforce_uid = 1'b0;
  logic [127:0]  dev_uid = '0;
  logic [127:0]  cred_uid = '0;
  logic [3:0]    key_revoked = '0;
  logic [1:0]    cred_key_idx = '0;
  logic [6:0]    dom_en;
  logic [2:0]    cmd_en;

  int errors = 0;
  int checks = 0;
  string phase = "R7";
  bit model_grant [10];

  always #4 clk = ~clk;

  dbg_domain_policy u_dut (
    .clk(clk), .rst_n(rst_n), .pol_cfg(pol_cfg), .grant_mask(grant_mask),
    .auth_ok(auth_ok), .enforce_uid(enforce_uid), .dev_uid(dev_uid),
    .cred_uid(cred_uid), .key_revoked(key_revoked), .cred_key_idx(cred_key_idx),
    .dom_en(dom_en), .cmd_en(cmd_en)
  );

  // reference model of granted entries
  always @(posedge clk) begin
    bit ok;
    ok = auth_ok;
    if (enforce_uid && cred_uid != dev_uid) ok = 0;
    if (key_revoked[cred_key_idx]) ok = 0;
    for (int k = 0; k < 10; k++) begin
      if (!rst_n) model_grant[k] <= 0;
      else if (ok && grant_mask[k]) model_grant[k] <= 1;
    end
  end

  function automatic logic [9:0] expect_en();
    logic [9:0] e;
    for (int k = 0; k < 10; k++) begin
      case (pol_cfg[2*k +: 2])
        2'b11:   e[k] = 1'b1;
        2'b01:   e[k] = model_grant[k] && rst_n;
        default: e[k] = 1'b0;
      endcase
    end
    return e;
  endfunction

  task automatic step();
    logic [9:0] exp_v, got;
    @(negedge clk);
    exp_v = expect_en();
    got = {cmd_en, dom_en};
    checks++;
    if (got !== exp_v) begin
      errors++;
      $display("FAIL %s: got %b expected %b", phase, got, exp_v);
    end
  endtask

  function automatic logic [19:0] cfg_of(input logic [1:0] c [10]);
    logic [19:0] v;
    for (int k = 0; k < 10; k++) v[2*k +: 2] = c[k];
    return v;
  endfunction

  task automatic strobe(input logic [9:0] m);
    grant_mask = m; auth_ok = 1'b1;
    step();
    auth_ok = 1'b0; grant_mask = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; step(); step(); rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [1:0] pat [10];
    pat = '{2'b01, 2'b11, 2'b00, 2'b10, 2'b01, 2'b01, 2'b11, 2'b01, 2'b00, 2'b01};
    pol_cfg = cfg_of(pat);
    dev_uid = {32'hA5A5_0001, 32'h1234_5678, 32'h0BAD_F00D, 32'hCAFE_0042};
    cred_uid = dev_uid;
    // R7 R2: permanent entries open while in reset
    phase = "R2 reset"; step(); step();
    rst_n = 1'b1;
    phase = "R1 R2 idle"; step(); step();
    // R3 R8: full grant opens gated entries only
    phase = "R3 full grant"; strobe(10'h3FF); step();
    // R6: mask toggles with strobe low do nothing
    phase = "R6 no strobe"; grant_mask = 10'h3FF; step(); step(); grant_mask = '0; step();
    // R7: reset clears grants
    phase = "R7 clear"; do_reset(); step();
    // R4: mismatching ID under enforcement
    enforce_uid = 1'b1; cred_uid = dev_uid ^ 128'h1;
    phase = "R4 uid mismatch"; strobe(10'h3FF); step();
    // R4: ID ignored when enforcement off
    enforce_uid = 1'b0;
    phase = "R4 no enforce"; strobe(10'h001); step();
    enforce_uid = 1'b1; cred_uid = dev_uid;
    phase = "R4 uid match"; strobe(10'h010); step();
    // R5: revoked key rejected, others accepted
    do_reset();
    key_revoked = 4'b0100; cred_key_idx = 2'd2;
    phase = "R5 revoked"; strobe(10'h3FF); step();
    cred_key_idx = 2'd3;
    phase = "R5 valid key"; strobe(10'h020); step();
    // R6: partial grants accumulate
    do_reset();
    phase = "R6 partial"; strobe(10'h011); step();
    phase = "R6 accumulate"; strobe(10'h280); step();
    phase = "R8 all gated"; pat = '{default: 2'b01}; pol_cfg = cfg_of(pat); step();
    // random sweep
    phase = "R1 R3 R4 R5 random";
    for (int n = 0; n < 400; n++) begin
      pol_cfg = 20'($urandom);
      grant_mask = 10'($urandom);
      auth_ok = ($urandom % 3) == 0;
      enforce_uid = $urandom % 2;
      cred_uid = ($urandom % 2) ? dev_uid : dev_uid ^ 128'($urandom);
      key_revoked = 4'($urandom);
      cred_key_idx = 2'($urandom);
      rst_n = ($urandom % 40) != 0;
      step();
    end
    rst_n = 1'b1; auth_ok = 1'b0;
    step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule